// File: doc/BRIEF.md
# Indirect Register Mailbox Bridge

The bridge lets a host with a 64-bit register port reach a separate register space that has 16-bit addresses and 32-bit data. The internal space is not mapped into the host window. The host reaches it through a mailbox of two words: a command word that holds the request and the target address, and a data word that carries write data out and read data back. A three-bit channel register chooses which of eight internal ports receives the access. A 64-bit scratch register is included for host-side sanity checks.

The host runs each access in the same way. For a write, it first loads the data word. It then writes the command word with the request bit set and the target address filled in. It polls the acknowledge bit until that bit reads one. For a read, the result is already in the data word at that point. Last, the host writes the command word with the acknowledge bit set, which clears the acknowledge and frees the mailbox.

The sequencer moves through four states. After reset it is in `ST_IDLE`. A valid command takes it to `ST_ISSUE` (transition *accept*). There it drives a single-cycle request and moves on to `ST_WAIT` (transition *issued*). In `ST_WAIT` it holds the response ready high. When the internal target returns a valid response, it goes to `ST_DONE` (transition *respond*) and the acknowledge bit reads one. A host write to the command word with the acknowledge bit set takes it back to `ST_IDLE` (transition *release*). The state holds in every other case.

Top module: `csr_mailbox_bridge`

## Requirements
- R1: After reset, all four host registers read zero, no internal request is driven and the response-ready output is low.
- R2: Host registers sit at byte offsets 0x30 (command), 0x38 (data), 0x40 (channel) and 0x48 (scratch). The scratch register stores all 64 bits written to it and reads them back.
- R3: In `ST_IDLE`, a command write with bit 1 set and bit 0 clear produces one request cycle. In that cycle the write-enable is high, the address is command bits 47:32, the write data is data-register bits 63:32 and the channel is channel-register bits 2:0.
- R4: A command write with bit 0 set and bit 1 clear produces one request cycle with the write-enable low. The returned data appears in data-register bits 31:0 no later than the cycle in which the acknowledge first reads one.
- R5: The acknowledge (command bit 2) becomes one only after a response is accepted, meaning response valid and response ready are high in the same cycle. Response ready is high only while an access is waiting for its response.
- R6: Once set, the acknowledge stays one until the host writes the command word with bit 2 set. After that write it reads zero.
- R7: A command that arrives while an access is in flight or an acknowledge is pending is ignored and issues no request.
- R8: A command with both bit 0 and bit 1 set is a no-op. It issues no request and raises no acknowledge.
- R9: The channel register keeps only bits 2:0, and its other bits read zero. Host writes to data-register bits 31:0 are ignored.
- R10: Write data, address and channel are captured when a command is accepted. Changing the data or channel register while an access is in flight does not change the request fields driven to the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe |
| host_addr | input | 8 | Host byte offset |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data for `host_addr` (combinational) |
| ib_req | output | 1 | Single-cycle internal request |
| ib_we | output | 1 | Request is a write |
| ib_addr | output | 16 | Internal register address |
| ib_wdata | output | 32 | Internal write data |
| ib_chan | output | 3 | Target port select |
| ib_rsp_valid | input | 1 | Target response valid |
| ib_rsp_ready | output | 1 | Bridge ready for a response |
| ib_rdata | input | 32 | Target read data |

## Verification
The hardest situation to reach from the ports is a host action that arrives while the access is still in `ST_WAIT`. This covers a new command, a rewrite of the data word and a change of channel. With an immediate response the window is only one cycle wide. The bench model of the target therefore has a programmable response delay. Stretching that delay to several cycles leaves room to rewrite the data and channel registers and to observe that response ready stays high while the acknowledge stays low. A separate scenario leaves the acknowledge pending and then sends a second command, which shows the ignore rule in `ST_DONE` rather than in `ST_WAIT`.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam logic [7:0] OFS_CMD     = 8'h30;
    localparam logic [7:0] OFS_DATA    = 8'h38;
    localparam logic [7:0] OFS_CHAN    = 8'h40;
    localparam logic [7:0] OFS_SCRATCH = 8'h48;

    localparam int BIT_RD    = 0;
    localparam int BIT_WR    = 1;
    localparam int BIT_ACK   = 2;
    localparam int ADDR_LSB  = 32;
    localparam int WDATA_LSB = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } mbx_state_e;
endpackage

// File: rtl/mbx_host_regs.sv
module mbx_host_regs
    import mbx_pkg::*;
#(
    parameter int HOST_AW = 8,
    parameter int IADDR_W = 16,
    parameter int IDATA_W = 32,
    parameter int CHAN_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr_en,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [63:0]        host_wdata,
    output logic [63:0]        host_rdata,
    input  logic               rd_cap,
    input  logic [IDATA_W-1:0] rd_cap_data,
    input  logic               st_ack,
    input  logic               st_pend_rd,
    input  logic               st_pend_wr,
    input  logic [IADDR_W-1:0] st_addr,
    output logic               cmd_we,
    output logic [IDATA_W-1:0] wdata_q,
    output logic [CHAN_W-1:0]  chan_q
);
    logic [IDATA_W-1:0] rdata_q;
    logic [63:0]        scratch_q;
    logic               hit_cmd, hit_data, hit_chan, hit_scr;

    assign hit_cmd  = host_addr == HOST_AW'(OFS_CMD);
    assign hit_data = host_addr == HOST_AW'(OFS_DATA);
    assign hit_chan = host_addr == HOST_AW'(OFS_CHAN);
    assign hit_scr  = host_addr == HOST_AW'(OFS_SCRATCH);
    assign cmd_we   = host_wr_en && hit_cmd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q   <= '0;
            wdata_q   <= '0;
            chan_q    <= '0;
            scratch_q <= '0;
        end else begin
            if (rd_cap)
                rdata_q <= rd_cap_data;
            if (host_wr_en && hit_data)
                wdata_q <= host_wdata[WDATA_LSB +: IDATA_W];
            if (host_wr_en && hit_chan)
                chan_q <= host_wdata[CHAN_W-1:0];
            if (host_wr_en && hit_scr)
                scratch_q <= host_wdata;
        end
    end

    always_comb begin
        host_rdata = '0;
        if (hit_cmd) begin
            host_rdata[BIT_RD]                = st_pend_rd;
            host_rdata[BIT_WR]                = st_pend_wr;
            host_rdata[BIT_ACK]               = st_ack;
            host_rdata[ADDR_LSB +: IADDR_W]   = st_addr;
        end else if (hit_data) begin
            host_rdata[IDATA_W-1:0]           = rdata_q;
            host_rdata[WDATA_LSB +: IDATA_W]  = wdata_q;
        end else if (hit_chan) begin
            host_rdata[CHAN_W-1:0]            = chan_q;
        end else if (hit_scr) begin
            host_rdata                        = scratch_q;
        end
    end

    AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr_en && hit_chan) |=> $stable(chan_q)); // R9
    AST_RDATA_ONLY_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_cap |=> $stable(rdata_q)); // R4
endmodule

// File: rtl/mbx_sequencer.sv
module mbx_sequencer
    import mbx_pkg::*;
#(
    parameter int IADDR_W = 16,
    parameter int IDATA_W = 32,
    parameter int CHAN_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_we,
    input  logic [63:0]        cmd_word,
    input  logic [IDATA_W-1:0] wdata_in,
    input  logic [CHAN_W-1:0]  chan_in,
    output logic               ib_req,
    output logic               ib_we,
    output logic [IADDR_W-1:0] ib_addr,
    output logic [IDATA_W-1:0] ib_wdata,
    output logic [CHAN_W-1:0]  ib_chan,
    input  logic               ib_rsp_valid,
    output logic               ib_rsp_ready,
    input  logic [IDATA_W-1:0] ib_rdata,
    output logic               ack,
    output logic               pend_rd,
    output logic               pend_wr,
    output logic [IADDR_W-1:0] last_addr,
    output logic               rd_cap,
    output logic [IDATA_W-1:0] rd_cap_data
);
    mbx_state_e         state_q, state_d;
    logic               accept, release_ack, rsp_take;
    logic               op_we_q;
    logic [IADDR_W-1:0] op_addr_q;
    logic [IDATA_W-1:0] op_wdata_q;
    logic [CHAN_W-1:0]  op_chan_q;

    assign accept      = cmd_we && (state_q == ST_IDLE)
                         && (cmd_word[BIT_RD] ^ cmd_word[BIT_WR]);
    assign release_ack = cmd_we && cmd_word[BIT_ACK] && (state_q == ST_DONE);
    assign rsp_take    = ib_rsp_valid && ib_rsp_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)      state_d = ST_ISSUE;
            ST_ISSUE:                  state_d = ST_WAIT;
            ST_WAIT:  if (rsp_take)    state_d = ST_DONE;
            ST_DONE:  if (release_ack) state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            op_we_q    <= 1'b0;
            op_addr_q  <= '0;
            op_wdata_q <= '0;
            op_chan_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_we_q    <= cmd_word[BIT_WR];
                op_addr_q  <= cmd_word[ADDR_LSB +: IADDR_W];
                op_wdata_q <= wdata_in;
                op_chan_q  <= chan_in;
            end
        end
    end

    always_comb begin
        ib_req       = (state_q == ST_ISSUE);
        ib_rsp_ready = (state_q == ST_WAIT);
        ack          = (state_q == ST_DONE);
        pend_rd      = (state_q == ST_ISSUE || state_q == ST_WAIT) && !op_we_q;
        pend_wr      = (state_q == ST_ISSUE || state_q == ST_WAIT) && op_we_q;
        ib_we        = op_we_q;
        ib_addr      = op_addr_q;
        ib_wdata     = op_wdata_q;
        ib_chan      = op_chan_q;
        last_addr    = op_addr_q;
        rd_cap       = rsp_take && !op_we_q;
        rd_cap_data  = ib_rdata;
    end

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req |=> !ib_req); // R3
    AST_ACK_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(ib_rsp_valid && ib_rsp_ready)); // R5
    AST_READY_NOT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ib_rsp_ready |-> !ack); // R5
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ack && !(cmd_we && cmd_word[BIT_ACK]) |=> ack); // R6
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ack && cmd_we && cmd_word[BIT_ACK] |=> !ack); // R6
    AST_NO_REQ_WHILE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ib_req); // R7
    AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ib_rsp_ready |=> $stable(ib_wdata) && $stable(ib_chan) && $stable(ib_addr)); // R10
endmodule

// File: rtl/csr_mailbox_bridge.sv
module csr_mailbox_bridge
    import mbx_pkg::*;
#(
    parameter int HOST_AW = 8,
    parameter int IADDR_W = 16,
    parameter int IDATA_W = 32,
    parameter int CHAN_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr_en,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [63:0]        host_wdata,
    output logic [63:0]        host_rdata,
    output logic               ib_req,
    output logic               ib_we,
    output logic [IADDR_W-1:0] ib_addr,
    output logic [IDATA_W-1:0] ib_wdata,
    output logic [CHAN_W-1:0]  ib_chan,
    input  logic               ib_rsp_valid,
    output logic               ib_rsp_ready,
    input  logic [IDATA_W-1:0] ib_rdata
);
    logic               cmd_we, rd_cap;
    logic [IDATA_W-1:0] rd_cap_data, wdata_q;
    logic [CHAN_W-1:0]  chan_q;
    logic               ack, pend_rd, pend_wr;
    logic [IADDR_W-1:0] last_addr;

    mbx_host_regs #(
        .HOST_AW(HOST_AW), .IADDR_W(IADDR_W), .IDATA_W(IDATA_W), .CHAN_W(CHAN_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rd_cap(rd_cap), .rd_cap_data(rd_cap_data),
        .st_ack(ack), .st_pend_rd(pend_rd), .st_pend_wr(pend_wr),
        .st_addr(last_addr),
        .cmd_we(cmd_we), .wdata_q(wdata_q), .chan_q(chan_q)
    );

    mbx_sequencer #(
        .IADDR_W(IADDR_W), .IDATA_W(IDATA_W), .CHAN_W(CHAN_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_we(cmd_we), .cmd_word(host_wdata),
        .wdata_in(wdata_q), .chan_in(chan_q),
        .ib_req(ib_req), .ib_we(ib_we), .ib_addr(ib_addr),
        .ib_wdata(ib_wdata), .ib_chan(ib_chan),
        .ib_rsp_valid(ib_rsp_valid), .ib_rsp_ready(ib_rsp_ready),
        .ib_rdata(ib_rdata),
        .ack(ack), .pend_rd(pend_rd), .pend_wr(pend_wr),
        .last_addr(last_addr), .rd_cap(rd_cap), .rd_cap_data(rd_cap_data)
    );
endmodule

// File: tb/test_csr_mailbox_bridge.sv
module test_csr_mailbox_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [7:0]  host_addr = 8'h00;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic        ib_req, ib_we, ib_rsp_ready;
    logic [15:0] ib_addr;
    logic [31:0] ib_wdata;
    logic [2:0]  ib_chan;
    logic        ib_rsp_valid = 1'b0;
    logic [31:0] ib_rdata = '0;

    int n_chk = 0, n_bad = 0;
    int req_cnt = 0, rsp_delay = 0, cnt = 0;
    bit armed = 0;
    logic        last_we;
    logic [15:0] last_addr;
    logic [31:0] last_wdata;
    logic [2:0]  last_chan;

    always #2.5 clk = ~clk;

    csr_mailbox_bridge i_csr_mailbox_bridge (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .ib_req(ib_req),
        .ib_we(ib_we), .ib_addr(ib_addr), .ib_wdata(ib_wdata), .ib_chan(ib_chan),
        .ib_rsp_valid(ib_rsp_valid), .ib_rsp_ready(ib_rsp_ready), .ib_rdata(ib_rdata)
    );

    // target model: responds rsp_delay cycles after seeing a request
    always @(negedge clk) begin
        if (ib_rsp_valid && !ib_rsp_ready) ib_rsp_valid = 1'b0;
        if (ib_req) begin
            req_cnt++;
            last_we = ib_we; last_addr = ib_addr;
            last_wdata = ib_wdata; last_chan = ib_chan;
            cnt = rsp_delay; armed = 1;
        end else if (armed) begin
            if (cnt == 0) begin ib_rsp_valid = 1'b1; armed = 0; end
            else cnt--;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic hread(input logic [7:0] a, output logic [63:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic wait_ack(input string req);
        logic [63:0] v;
        for (int i = 0; i < 40; i++) begin
            hread(8'h30, v);
            if (v[2]) return;
        end
        chk(req, 64'd0, 64'd1);
    endtask

    task automatic t_reset;
        logic [63:0] v;
        hread(8'h30, v); chk("R1 cmd", v, 0);
        hread(8'h38, v); chk("R1 data", v, 0);
        hread(8'h40, v); chk("R1 chan", v, 0);
        hread(8'h48, v); chk("R1 scratch", v, 0);
        chk("R1 req/ready", {ib_req, ib_rsp_ready}, 0);
    endtask

    task automatic t_regs;
        logic [63:0] v;
        hwrite(8'h48, 64'hDEAD_BEEF_0123_4567);
        hread(8'h48, v); chk("R2 scratch", v, 64'hDEAD_BEEF_0123_4567);
        hwrite(8'h40, 64'hFFFF_FFFF_FFFF_FFFE);
        hread(8'h40, v); chk("R9 chan mask", v, 64'd6);
        hwrite(8'h38, 64'h1357_9BDF_FFFF_FFFF);
        hread(8'h38, v); chk("R9 data low ignored", v, 64'h1357_9BDF_0000_0000);
    endtask

    task automatic t_write;
        logic [63:0] v;
        int base = req_cnt;
        rsp_delay = 0;
        hwrite(8'h38, 64'hCAFE_F00D_0000_0000);
        hwrite(8'h40, 64'd5);
        hwrite(8'h30, 64'h0000_1234_0000_0002);
        wait_ack("R3 ack");
        chk("R3 one req", req_cnt, base + 1);
        chk("R3 fields", {last_we, last_addr, last_wdata, last_chan},
            {1'b1, 16'h1234, 32'hCAFEF00D, 3'd5});
        hread(8'h30, v); chk("R6 ack+addr", v, 64'h0000_1234_0000_0004);
        repeat (5) @(negedge clk);
        hread(8'h30, v); chk("R6 ack held", v[2], 1);
        hwrite(8'h30, 64'd4);
        hread(8'h30, v); chk("R6 ack cleared", v[2], 0);
    endtask

    task automatic t_read;
        logic [63:0] v;
        rsp_delay = 4;
        ib_rdata = 32'hA5A5_5A5A;
        hwrite(8'h30, 64'h0000_00FF_0000_0001);
        hread(8'h30, v); chk("R5 no early ack", v[2:0], 3'b001);
        chk("R5 ready while waiting", ib_rsp_ready, 1);
        wait_ack("R4 ack");
        chk("R4 read req", last_we, 0);
        hread(8'h38, v); chk("R4 read data", v[31:0], 32'hA5A5_5A5A);
        chk("R5 ready low after", ib_rsp_ready, 0);
    endtask

    task automatic t_pending;
        logic [63:0] v;
        int base = req_cnt;
        hwrite(8'h30, 64'h0000_0777_0000_0002);
        repeat (6) @(negedge clk);
        chk("R7 ignored while ack", req_cnt, base);
        hread(8'h30, v); chk("R7 addr unchanged", v[47:32], 16'h00FF);
        hwrite(8'h30, 64'd4);
        hread(8'h30, v); chk("R6 cleared", v[2], 0);
        rsp_delay = 5;
        hwrite(8'h30, 64'h0000_0100_0000_0001);
        hwrite(8'h30, 64'h0000_0200_0000_0002);
        wait_ack("R7 ack");
        chk("R7 ignored in flight", req_cnt, base + 1);
        chk("R7 first kept", {last_we, last_addr}, {1'b0, 16'h0100});
        hwrite(8'h30, 64'd4);
    endtask

    task automatic t_both;
        logic [63:0] v;
        int base = req_cnt;
        hwrite(8'h30, 64'h0000_0042_0000_0003);
        repeat (8) @(negedge clk);
        chk("R8 no req", req_cnt, base);
        hread(8'h30, v); chk("R8 no ack", v[2:0], 0);
    endtask

    task automatic t_capture;
        logic [63:0] v;
        rsp_delay = 8;
        hwrite(8'h38, 64'h1111_1111_0000_0000);
        hwrite(8'h40, 64'd3);
        hwrite(8'h30, 64'h0000_0055_0000_0002);
        hwrite(8'h38, 64'h2222_2222_0000_0000);
        hwrite(8'h40, 64'd1);
        chk("R10 wdata held", ib_wdata, 32'h1111_1111);
        chk("R10 chan held", ib_chan, 3);
        wait_ack("R10 ack");
        chk("R10 captured", {last_wdata, last_chan}, {32'h1111_1111, 3'd3});
        hwrite(8'h30, 64'd4);
        hread(8'h30, v); chk("R6 final clear", v[2], 0);
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_write();
        t_read();
        t_pending();
        t_both();
        t_capture();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule